// File: doc/BRIEF.md
# Hysteresis Detection Search Engine

This block decides whether a tunable amplifier is bistable at its present tuning. It runs a binary search over the code of an offset-compensation DAC. At every trial code it forces the amplifier output high, releases it, waits for the output to settle and samples a comparator. It then does the same with the output forced low. The two samples form a two-bit signature, and the block makes a three-way decision on it. The search either narrows the code interval from below, narrows it from above, or stops at once because hysteresis has been found.

The amplifier, the DAC and the comparator all sit outside the block. The block sees only one comparator bit. It drives the DAC code, one strobe that forces the output high, one strobe that forces it low, and a sample enable. A start pulse launches a search. The block answers with a single-cycle done pulse and a result bit that is 1 when bistability was found.

Top module: `hse_search_engine`

## Requirements
- R1: After reset, `dac_code` is 0. `pull_up`, `pull_down`, `sample_en`, `done`, `bif_found` and `sig_err` are all 0.
- R2: The search keeps a low bound that starts at 0 and a high bound that starts at 2^CODE_W. Each trial code is (low + high) / 2, rounded down, so the first trial code is 2^(CODE_W-1).
- R3: Each probe has four phases in a fixed order:
  - `pull_up` is asserted for the force time;
  - both strobes are released for the settle time, and the comparator is sampled as OH in the last cycle of that wait, with `sample_en` high;
  - `pull_down` is asserted for the force time;
  - both strobes are released for the settle time, and the comparator is sampled as OL in the same way.
  `pull_up` and `pull_down` are never asserted together.
- R4: A signature {OH,OL} = 2'b10 ends the search at once with `bif_found` = 1.
- R5: A signature of 2'b11 moves the low bound to the trial code. A signature of 2'b00 moves the high bound to the trial code.
- R6: If CODE_W probes finish without a 2'b10 signature, the search ends with `bif_found` = 0.
- R7: A signature of 2'b01 ends the search with `bif_found` = 0. It also sets `sig_err`, which stays set until reset.
- R8: The force time is `force_len` cycles and the settle time is `settle_len` cycles, where a value of 0 counts as 1. A search of n probes raises `done` exactly n*(2F+2S+2) cycles after the clock edge that accepts `start`. Here F and S are the effective force and settle times.
- R9: A `start` pulse that arrives while a search is running has no effect on that search.
- R10: `done` is high for one cycle. `bif_found` is valid in that cycle and keeps its value until the next search ends.
- R11: After `done`, `dac_code` keeps the last trial code until a new search begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a search when the block is idle |
| force_len | input | CNT_W | Cycles each strobe is held |
| settle_len | input | CNT_W | Cycles of release before each comparator sample |
| cmp_in | input | 1 | Comparator result from the amplifier |
| dac_code | output | CODE_W | Trial code for the offset-compensation DAC |
| pull_up | output | 1 | Forces the amplifier output high |
| pull_down | output | 1 | Forces the amplifier output low |
| sample_en | output | 1 | Marks the cycle in which the comparator is sampled |
| done | output | 1 | One-cycle end-of-search pulse |
| bif_found | output | 1 | 1 when hysteresis was detected |
| sig_err | output | 1 | Sticky flag for an invalid signature |

## Verification
The hardest case to reach is a 2'b10 signature at a chosen depth of the search. It needs the comparator to answer differently after the high probe and after the low probe, and only for trial codes inside a window. The bench models the amplifier as a code-dependent hysteresis band with a lower and an upper threshold. With a 4-bit code it sweeps every ordered pair of thresholds, so bistability is found at every depth and also never found. An inverting mode of the same model produces the invalid 2'b01 signature, which tests the sticky error flag.

// File: rtl/hse_pkg.sv
package hse_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_FORCE_H,
    S_SETTLE_H,
    S_FORCE_L,
    S_SETTLE_L,
    S_DECIDE
  } hse_state_e;
endpackage

// File: rtl/hse_timer.sv
module hse_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/hse_bounds.sv
module hse_bounds #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              latch_trial,
  input  logic              raise_low,
  input  logic              lower_high,
  output logic [CODE_W-1:0] trial
);
  localparam logic [CODE_W:0] TOP = (CODE_W+1)'(1) << CODE_W;

  logic [CODE_W:0]   low_q, high_q;
  logic [CODE_W-1:0] mid;

  assign mid = CODE_W'((low_q + high_q) >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= '0;
      high_q <= TOP;
      trial  <= '0;
    end else begin
      if (init) begin
        low_q  <= '0;
        high_q <= TOP;
      end else begin
        if (raise_low)  low_q  <= {1'b0, trial};
        if (lower_high) high_q <= {1'b0, trial};
      end
      if (latch_trial) trial <= mid;
    end
  end
endmodule

// File: rtl/hse_ctrl.sv
module hse_ctrl
  import hse_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] force_len,
  input  logic [CNT_W-1:0] settle_len,
  input  logic             cmp_in,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             bnd_init,
  output logic             bnd_latch,
  output logic             bnd_raise_low,
  output logic             bnd_lower_high,
  output logic             pull_up,
  output logic             pull_down,
  output logic             sample_en,
  output logic             done,
  output logic             bif_found,
  output logic             sig_err
);
  localparam int STEP_W = $clog2(CODE_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CODE_W - 1);

  hse_state_e        state, state_n;
  logic [STEP_W-1:0] step_q;
  logic              oh_q, ol_q;
  logic              finish, finish_bif, finish_err;

  always_comb begin
    state_n        = state;
    tmr_load       = 1'b0;
    bnd_init       = 1'b0;
    bnd_latch      = 1'b0;
    bnd_raise_low  = 1'b0;
    bnd_lower_high = 1'b0;
    finish         = 1'b0;
    finish_bif     = 1'b0;
    finish_err     = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        bnd_init = 1'b1;
        state_n  = S_LOAD;
      end
      S_LOAD: begin
        bnd_latch = 1'b1;
        tmr_load  = 1'b1;
        state_n   = S_FORCE_H;
      end
      S_FORCE_H: if (tmr_expired) begin
        tmr_load = 1'b1;
        state_n  = S_SETTLE_H;
      end
      S_SETTLE_H: if (tmr_expired) begin
        tmr_load = 1'b1;
        state_n  = S_FORCE_L;
      end
      S_FORCE_L: if (tmr_expired) begin
        tmr_load = 1'b1;
        state_n  = S_SETTLE_L;
      end
      S_SETTLE_L: if (tmr_expired) state_n = S_DECIDE;
      S_DECIDE: begin
        unique case ({oh_q, ol_q})
          2'b10: begin
            finish     = 1'b1;
            finish_bif = 1'b1;
          end
          2'b01: begin
            finish     = 1'b1;
            finish_err = 1'b1;
          end
          2'b11: begin
            bnd_raise_low = 1'b1;
            finish        = (step_q == LAST_STEP);
          end
          default: begin
            bnd_lower_high = 1'b1;
            finish         = (step_q == LAST_STEP);
          end
        endcase
        state_n = finish ? S_IDLE : S_LOAD;
      end
      default: state_n = S_IDLE;
    endcase
  end

  assign tmr_len   = (state == S_LOAD || state == S_SETTLE_H) ? force_len : settle_len;
  assign pull_up   = (state == S_FORCE_H);
  assign pull_down = (state == S_FORCE_L);
  assign sample_en = (state == S_SETTLE_H || state == S_SETTLE_L) && tmr_expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step_q    <= '0;
      oh_q      <= 1'b0;
      ol_q      <= 1'b0;
      done      <= 1'b0;
      bif_found <= 1'b0;
      sig_err   <= 1'b0;
    end else begin
      state <= state_n;
      done  <= finish;
      if (bnd_init) step_q <= '0;
      else if (state == S_DECIDE && !finish) step_q <= step_q + 1'b1;
      if (state == S_SETTLE_H && tmr_expired) oh_q <= cmp_in;
      if (state == S_SETTLE_L && tmr_expired) ol_q <= cmp_in;
      if (finish) bif_found <= finish_bif;
      if (finish_err) sig_err <= 1'b1;
    end
  end
endmodule

// File: rtl/hse_search_engine.sv
module hse_search_engine #(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  force_len,
  input  logic [CNT_W-1:0]  settle_len,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] dac_code,
  output logic              pull_up,
  output logic              pull_down,
  output logic              sample_en,
  output logic              done,
  output logic              bif_found,
  output logic              sig_err
);
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_len;
  logic             bnd_init, bnd_latch, bnd_raise_low, bnd_lower_high;

  hse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .expired(tmr_expired)
  );

  hse_bounds #(.CODE_W(CODE_W)) u_bounds (
    .clk(clk), .rst(rst), .init(bnd_init), .latch_trial(bnd_latch),
    .raise_low(bnd_raise_low), .lower_high(bnd_lower_high), .trial(dac_code)
  );

  hse_ctrl #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .force_len(force_len),
    .settle_len(settle_len), .cmp_in(cmp_in), .tmr_expired(tmr_expired),
    .tmr_load(tmr_load), .tmr_len(tmr_len), .bnd_init(bnd_init),
    .bnd_latch(bnd_latch), .bnd_raise_low(bnd_raise_low),
    .bnd_lower_high(bnd_lower_high), .pull_up(pull_up), .pull_down(pull_down),
    .sample_en(sample_en), .done(done), .bif_found(bif_found), .sig_err(sig_err)
  );
endmodule

// File: rtl/hse_search_chk.sv
module hse_search_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CODE_W-1:0] dac_code,
  input logic              pull_up,
  input logic              pull_down,
  input logic              sample_en,
  input logic              done,
  input logic              sig_err
);
  logic parked;

  always_ff @(posedge clk) begin
    if (rst) parked <= 1'b0;
    else if (done) parked <= 1'b1;
    else if (start) parked <= 1'b0;
  end

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pull_up && pull_down));

  a_r3_sample_released: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> (!pull_up && !pull_down));

  a_r3_code_steady_at_sample: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !$past(rst)) |-> $stable(dac_code));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    sig_err |=> sig_err);

  a_r11_code_hold: assert property (@(posedge clk) disable iff (rst)
    (parked && !start) |=> $stable(dac_code));
endmodule

bind hse_search_engine hse_search_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .dac_code(dac_code),
  .pull_up(pull_up), .pull_down(pull_down), .sample_en(sample_en),
  .done(done), .sig_err(sig_err)
);

// File: tb/tb_hse_search_engine.sv
module tb_hse_search_engine;
  localparam int CW = 4;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NW-1:0] force_len = NW'(2);
  logic [NW-1:0] settle_len = NW'(4);
  logic          cmp_in;
  logic [CW-1:0] dac_code;
  logic          pull_up, pull_down, sample_en, done, bif_found, sig_err;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  logic [CW:0] lth = '0, hth = '0;
  logic        errmode = 1'b0;
  logic        last_up = 1'b0;
  logic        pu_prev = 1'b0;
  logic        tr_clr = 1'b0;
  int          tr_n = 0;
  int          tr [0:15];
  logic        err_exp = 1'b0;

  always #4 clk = ~clk;

  hse_search_engine #(.CODE_W(CW), .CNT_W(NW)) dut (
    .clk(clk), .rst(rst), .start(start), .force_len(force_len),
    .settle_len(settle_len), .cmp_in(cmp_in), .dac_code(dac_code),
    .pull_up(pull_up), .pull_down(pull_down), .sample_en(sample_en),
    .done(done), .bif_found(bif_found), .sig_err(sig_err)
  );

  // amplifier model: hysteresis band [lth, hth) on the trial code
  assign cmp_in = errmode ? !last_up
                : (last_up ? ({1'b0, dac_code} < hth) : ({1'b0, dac_code} < lth));

  always @(posedge clk) begin
    if (pull_up) last_up <= 1'b1;
    else if (pull_down) last_up <= 1'b0;
    pu_prev <= pull_up;
    if (tr_clr) tr_n <= 0;
    else if (pull_up && !pu_prev && tr_n < 16) begin
      tr[tr_n] <= int'(dac_code);
      tr_n <= tr_n + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 150000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared = compared + 1;
    if (!ok) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int lt, input int ht, input bit em,
                     input int f, input int s, input bit busy);
    int lo, hi, n, mid, per, cnt, fe, se;
    bit res, oh, ol;
    int exp_tr [0:15];
    lo = 0; hi = 1 << CW; n = 0; res = 0;
    for (int k = 0; k < CW; k++) begin
      mid = (lo + hi) / 2;
      exp_tr[k] = mid;
      n = k + 1;
      oh = em ? 1'b0 : (mid < ht);
      ol = em ? 1'b1 : (mid < lt);
      if (oh && !ol) begin res = 1; break; end
      if (!oh && ol) break;
      if (oh) lo = mid; else hi = mid;
    end
    if (em) err_exp = 1'b1;
    fe = (f == 0) ? 1 : f;
    se = (s == 0) ? 1 : s;
    per = 2 * fe + 2 * se + 2;

    @(negedge clk);
    lth = (CW+1)'(lt); hth = (CW+1)'(ht); errmode = em;
    force_len = NW'(f); settle_len = NW'(s);
    start = 1'b1; tr_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; tr_clr = 1'b0;
    cnt = 1;
    while (!done && cnt < 2000) begin
      @(posedge clk); #1;
      if (busy) start = (cnt == 3);
      cnt = cnt + 1;
    end
    start = 1'b0;
    cnt = cnt - 1;
    // R8 timing, R4/R6/R7 outcome
    check(cnt == n * per, "R8 cycles to done", cnt, n * per);
    if (busy) check(cnt == n * per, "R9 busy start ignored", cnt, n * per);
    check(bif_found == res, res ? "R4 bifurcation result" : "R6 no-bifurcation result",
          int'(bif_found), int'(res));
    check(sig_err == err_exp, "R7 sticky error flag", int'(sig_err), int'(err_exp));
    // R2/R5 trial code sequence
    check(tr_n == n, "R2 number of probes", tr_n, n);
    for (int k = 0; k < n && k < tr_n; k++)
      check(tr[k] == exp_tr[k], k == 0 ? "R2 first trial code" : "R5 bound update trial",
            tr[k], exp_tr[k]);
    check(int'(dac_code) == exp_tr[n-1], "R11 final code", int'(dac_code), exp_tr[n-1]);
    @(posedge clk); #1;
    check(done == 1'b0, "R10 done single cycle", int'(done), 0);
    check(bif_found == res, "R10 result held", int'(bif_found), int'(res));
    repeat (3) @(posedge clk);
    #1;
    check(int'(dac_code) == exp_tr[n-1], "R11 code held after done",
          int'(dac_code), exp_tr[n-1]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(dac_code == '0, "R1 reset code", int'(dac_code), 0);
    check({pull_up, pull_down, sample_en, done, bif_found, sig_err} == 6'b0,
          "R1 reset outputs",
          int'({pull_up, pull_down, sample_en, done, bif_found, sig_err}), 0);
    @(negedge clk);
    rst = 1'b0;

    // exhaustive sweep of hysteresis bands
    for (int lt = 0; lt <= 16; lt++)
      for (int ht = lt; ht <= 16; ht++)
        run(lt, ht, 1'b0, 2, 4, 1'b0);

    // R8 phase-length variants, including zero
    run(5, 11, 1'b0, 0, 0, 1'b0);
    run(3, 3, 1'b0, 1, 3, 1'b0);
    run(15, 16, 1'b0, 5, 1, 1'b0);
    // R9 start while busy
    run(9, 10, 1'b0, 2, 4, 1'b1);
    run(0, 0, 1'b0, 2, 2, 1'b1);
    // R7 invalid signature, then sticky over a clean run
    run(4, 12, 1'b1, 2, 4, 1'b0);
    run(0, 16, 1'b0, 2, 4, 1'b0);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    err_exp = 1'b0;
    #1;
    check(sig_err == 1'b0, "R7 error cleared by reset", int'(sig_err), 0);
    run(6, 7, 1'b0, 2, 4, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule